// File: doc/BRIEF.md
# Masked Condition-Field Test and Move Unit

This block keeps a 32-bit condition register made of eight 4-bit fields. It applies one single-cycle operation per valid strobe. The opcode chooses one of three operations.

- A field test compares a source field with a 4-bit mode pattern under a 4-bit mask.
- A masked move copies a source field through the mask.
- A sign test compares the low bit of a 64-bit integer operand with the mode pattern.

Each operation writes its 4-bit result into one destination field.

A merge flag selects how the destination is written. With the flag set, the old destination bits under a zero mask bit are kept and the new bits are merged in. With the flag clear, the field is overwritten and every masked-out bit becomes zero. The whole register is always visible on an output. A one-cycle done pulse follows every accepted request.

Top module: `cond_field_unit`

## Requirements
- R1: While reset is asserted, and after reset is released, every field of `cr_o` reads zero and `done_o` is low.
- R2: Field k (k = 0..7) sits at `cr_o[31-4k : 28-4k]`. In every field and in the `mask_i` and `mode_i` ports, logical bit 0 is the most significant port bit (port bit 3), and logical bit i is port bit 3-i.
- R3: Opcode 0 (field test): for each i, result bit i = mask[i] AND (mode[i] == source field bit i).
- R4: Opcode 1 (masked move): result = mask AND source field, bit by bit.
- R5: Opcode 2 (sign test): for each i, result bit i = mask[i] AND (mode[i] == `opnd_i[0]`). Port bit 0 is the least significant bit of the operand.
- R6: With `merge_i` = 1, destination bits whose mask bit is 0 keep their previous value.
- R7: With `merge_i` = 0 and opcodes 0 to 2, destination bits whose mask bit is 0 become 0.
- R8: A request updates only the destination field, at the clock edge where `valid_i` is sampled high. Without `valid_i`, the register does not change.
- R9: `done_o` is high for exactly the cycle after each cycle in which `valid_i` is sampled high, and low otherwise.
- R10: Opcode 3 leaves the register unchanged but still produces the done pulse.
- R11: When the source and destination indices are equal, the result uses the field value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation select (0 test, 1 move, 2 sign test, 3 none) |
| dst_idx_i | input | 3 | Destination field index |
| src_idx_i | input | 3 | Source field index |
| mask_i | input | 4 | Bit mask, logical bit 0 in port bit 3 |
| mode_i | input | 4 | Comparison pattern, logical bit 0 in port bit 3 |
| merge_i | input | 1 | 1: keep masked-out bits, 0: clear them |
| opnd_i | input | 64 | Integer operand; only bit 0 is used |
| cr_o | output | 32 | Full condition register |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a merged write whose source field is also its destination. In that case the read-before-write order and the keep-old-bits path act on the same nibble in one cycle. The directed part of the stimulus first seeds several fields with distinct nibbles through the sign test and the move. It then issues same-index requests with partial masks under both merge settings. A long pseudo-random phase follows, with narrow index ranges so that aliasing recurs often. A behavioural model is compared with the whole register and the done pulse on every cycle.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    OP_TEST = 2'd0,
    OP_MOVE = 2'd1,
    OP_SIGN = 2'd2,
    OP_NONE = 2'd3
  } cfu_op_e;
endpackage

// File: rtl/cfu_field_eval.sv
// Computes the masked, unmerged 4-bit result of one operation.
module cfu_field_eval #(
  parameter int FW = 4
) (
  input  logic [1:0]    op_i,
  input  logic [FW-1:0] src_fld_i,
  input  logic [FW-1:0] mask_i,
  input  logic [FW-1:0] mode_i,
  input  logic          opnd_bit_i,
  output logic [FW-1:0] raw_o,
  output logic          wr_en_o
);
  import cfu_pkg::*;

  logic [FW-1:0] hit_fld;
  logic [FW-1:0] hit_sgn;

  genvar b;
  generate
    for (b = 0; b < FW; b++) begin : g_bit
      assign hit_fld[b] = ~(mode_i[b] ^ src_fld_i[b]);
      assign hit_sgn[b] = ~(mode_i[b] ^ opnd_bit_i);
    end
  endgenerate

  always_comb begin
    raw_o   = '0;
    wr_en_o = 1'b1;
    unique case (cfu_op_e'(op_i))
      OP_TEST: raw_o = mask_i & hit_fld;
      OP_MOVE: raw_o = mask_i & src_fld_i;
      OP_SIGN: raw_o = mask_i & hit_sgn;
      default: wr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfu_merge.sv
// Chooses between read-modify-write and plain overwrite of the destination.
module cfu_merge #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] raw_i,
  input  logic [FW-1:0] old_i,
  input  logic [FW-1:0] mask_i,
  input  logic          merge_i,
  output logic [FW-1:0] new_o
);
  always_comb begin
    if (merge_i) new_o = raw_i | (old_i & ~mask_i);
    else         new_o = raw_i;
  end
endmodule

// File: rtl/cfu_regfile.sv
// Eight field registers, each with its own clock enable, two read ports.
module cfu_regfile #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4,
  localparam int IDXW   = $clog2(NFIELDS),
  localparam int CRW    = NFIELDS * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [FW-1:0]   wdata_i,
  input  logic [IDXW-1:0] ridx_a_i,
  input  logic [IDXW-1:0] ridx_b_i,
  output logic [FW-1:0]   rdata_a_o,
  output logic [FW-1:0]   rdata_b_o,
  output logic [CRW-1:0]  cr_o
);
  logic [FW-1:0] fld_q [NFIELDS];
  logic [NFIELDS-1:0] fld_en;

  genvar g;
  generate
    for (g = 0; g < NFIELDS; g++) begin : g_fld
      assign fld_en[g] = we_i && (widx_i == IDXW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         fld_q[g] <= '0;
        else if (fld_en[g]) fld_q[g] <= wdata_i;
      end

      assign cr_o[CRW-1-FW*g -: FW] = fld_q[g];
    end
  endgenerate

  assign rdata_a_o = fld_q[ridx_a_i];
  assign rdata_b_o = fld_q[ridx_b_i];
endmodule

// File: rtl/cond_field_unit.sv
module cond_field_unit #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4,
  parameter int OPW     = 64,
  localparam int IDXW   = $clog2(NFIELDS),
  localparam int CRW    = NFIELDS * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [IDXW-1:0] dst_idx_i,
  input  logic [IDXW-1:0] src_idx_i,
  input  logic [FW-1:0]   mask_i,
  input  logic [FW-1:0]   mode_i,
  input  logic            merge_i,
  input  logic [OPW-1:0]  opnd_i,
  output logic [CRW-1:0]  cr_o,
  output logic            done_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [FW-1:0] src_fld, dst_old, raw, new_fld;
  logic          wr_en;
  logic          unused_opnd_hi;

  assign unused_opnd_hi = ^opnd_i[OPW-1:1];

  cfu_field_eval #(.FW(FW)) u_eval (
    .op_i       (op_i),
    .src_fld_i  (src_fld),
    .mask_i     (mask_i),
    .mode_i     (mode_i),
    .opnd_bit_i (opnd_i[0]),
    .raw_o      (raw),
    .wr_en_o    (wr_en)
  );

  cfu_merge #(.FW(FW)) u_merge (
    .raw_i   (raw),
    .old_i   (dst_old),
    .mask_i  (mask_i),
    .merge_i (merge_i),
    .new_o   (new_fld)
  );

  cfu_regfile #(.NFIELDS(NFIELDS), .FW(FW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we_i      (valid_i && wr_en),
    .widx_i    (dst_idx_i),
    .wdata_i   (new_fld),
    .ridx_a_i  (src_idx_i),
    .ridx_b_i  (dst_idx_i),
    .rdata_a_o (src_fld),
    .rdata_b_o (dst_old),
    .cr_o      (cr_o)
  );

  // Completion pulse: next-state and register kept apart.
  logic done_d, done_q;
  always_comb done_d = valid_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= done_d;
  end
  assign done_o = done_q;
endmodule

// File: rtl/cfu_chk.sv
module cfu_chk #(
  parameter int NFIELDS = 8,
  parameter int FW      = 4,
  localparam int IDXW   = $clog2(NFIELDS),
  localparam int CRW    = NFIELDS * FW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [1:0]      op_i,
  input logic [IDXW-1:0] dst_idx_i,
  input logic [IDXW-1:0] src_idx_i,
  input logic [FW-1:0]   mask_i,
  input logic            merge_i,
  input logic [CRW-1:0]  cr_o,
  input logic            done_o
);
  function automatic logic [FW-1:0] fld(input logic [CRW-1:0] cr, input logic [IDXW-1:0] k);
    return cr[CRW-1-FW*k -: FW];
  endfunction

  p_done_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(cr_o));

  p_unused_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd3) |=> $stable(cr_o));

  p_merge_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && merge_i) |=>
      ((fld(cr_o, $past(dst_idx_i)) & ~$past(mask_i)) ==
       (fld($past(cr_o), $past(dst_idx_i)) & ~$past(mask_i))));

  p_nomerge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !merge_i && op_i != 2'd3) |=>
      ((fld(cr_o, $past(dst_idx_i)) & ~$past(mask_i)) == '0));

  p_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd1) |=>
      ((fld(cr_o, $past(dst_idx_i)) & $past(mask_i)) ==
       (fld($past(cr_o), $past(src_idx_i)) & $past(mask_i))));

  genvar g;
  generate
    for (g = 0; g < NFIELDS; g++) begin : g_other
      p_other_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dst_idx_i != IDXW'(g)) |=>
          (fld(cr_o, IDXW'(g)) == fld($past(cr_o), IDXW'(g))));
    end
  endgenerate
endmodule

bind cond_field_unit cfu_chk #(.NFIELDS(NFIELDS), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .dst_idx_i (dst_idx_i),
  .src_idx_i (src_idx_i),
  .mask_i    (mask_i),
  .merge_i   (merge_i),
  .cr_o      (cr_o),
  .done_o    (done_o)
);

// File: tb/cond_field_unit_tb_top.sv
`timescale 1ns/1ps
module cond_field_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [2:0]  dst_idx_i = '0;
  logic [2:0]  src_idx_i = '0;
  logic [3:0]  mask_i = '0;
  logic [3:0]  mode_i = '0;
  logic        merge_i = 1'b0;
  logic [63:0] opnd_i = '0;
  logic [31:0] cr_o;
  logic        done_o;

  always #2.5 clk = ~clk;

  cond_field_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .dst_idx_i(dst_idx_i), .src_idx_i(src_idx_i), .mask_i(mask_i),
    .mode_i(mode_i), .merge_i(merge_i), .opnd_i(opnd_i),
    .cr_o(cr_o), .done_o(done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [3:0] model_fld [8];
  logic       model_done = 1'b0;
  string      pend_tag = "R1";

  function automatic logic [31:0] model_cr();
    logic [31:0] v;
    for (int k = 0; k < 8; k++) v[31-4*k -: 4] = model_fld[k];
    return v;
  endfunction

  task automatic compare();
    logic [31:0] e;
    e = model_cr();
    n_cmp++;
    if (cr_o !== e) begin
      n_bad++;
      $display("FAIL %s: cr_o actual %h expected %h", pend_tag, cr_o, e);
    end
    n_cmp++;
    if (done_o !== model_done) begin
      n_bad++;
      $display("FAIL R9 (%s): done_o actual %b expected %b", pend_tag, done_o, model_done);
    end
  endtask

  // One cycle: check the outputs of the previous cycle, then apply new inputs.
  task automatic step(input logic v, input logic [1:0] op, input int d, input int s,
                      input logic [3:0] mk, input logic [3:0] md, input logic mg,
                      input logic [63:0] ra, input string tag);
    logic [3:0] srcv, oldv, r;
    @(negedge clk);
    compare();
    valid_i = v; op_i = op; dst_idx_i = d[2:0]; src_idx_i = s[2:0];
    mask_i = mk; mode_i = md; merge_i = mg; opnd_i = ra;
    pend_tag = tag;
    model_done = v;
    if (v && op != 2'd3) begin
      srcv = model_fld[s];
      oldv = model_fld[d];
      for (int i = 0; i < 4; i++) begin
        int p;
        p = 3 - i;                       // logical bit i lives in port bit 3-i
        case (op)
          2'd0: r[p] = mk[p] && (md[p] == srcv[p]);
          2'd1: r[p] = mk[p] && srcv[p];
          default: r[p] = mk[p] && (md[p] == ra[0]);
        endcase
        if (!mk[p]) r[p] = mg ? oldv[p] : 1'b0;
      end
      model_fld[d] = r;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 0, 0, 4'h0, 4'h0, 1'b0, 64'h0, tag);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model_fld[k] = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                                   // R1 during reset
    rst_n = 1'b1;
    repeat (3) idle("R1");                       // R1 after release

    // R5, R2: sign test, operand LSB 1, all mask and mode set -> field 0 = F
    step(1'b1, 2'd2, 0, 0, 4'hF, 4'hF, 1'b0, 64'h1, "R5");
    // R5: upper operand bits ignored, LSB 0, mode 1010 -> field 7 = 0101
    step(1'b1, 2'd2, 7, 0, 4'hF, 4'hA, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, "R5");
    // R4: move field 0 into field 3 through mask 1100
    step(1'b1, 2'd1, 3, 0, 4'hC, 4'h0, 1'b0, 64'h0, "R4");
    // R3: test field 3 against 1010 -> field 5
    step(1'b1, 2'd0, 5, 3, 4'hF, 4'hA, 1'b0, 64'h0, "R3");
    // R6: merge into field 0, partial mask
    step(1'b1, 2'd0, 0, 5, 4'h3, 4'h1, 1'b1, 64'h0, "R6");
    // R7: overwrite field 7, partial mask clears the rest
    step(1'b1, 2'd1, 7, 0, 4'h6, 4'h0, 1'b0, 64'h0, "R7");
    // R11: source equals destination, with and without merge
    step(1'b1, 2'd0, 0, 0, 4'h5, 4'h0, 1'b1, 64'h0, "R11");
    step(1'b1, 2'd0, 5, 5, 4'h9, 4'h9, 1'b0, 64'h0, "R11");
    step(1'b1, 2'd1, 3, 3, 4'h8, 4'h0, 1'b1, 64'h0, "R11");
    // R10: unused opcode, all bits set, register must hold, done must pulse
    step(1'b1, 2'd3, 0, 0, 4'hF, 4'hF, 1'b0, 64'h1, "R10");
    step(1'b1, 2'd3, 7, 2, 4'h0, 4'h0, 1'b1, 64'h0, "R10");
    // R8: idle cycles hold the register
    repeat (3) idle("R8");
    // R6, R7: sign test into an untouched field under both merge settings
    step(1'b1, 2'd2, 2, 0, 4'hA, 4'hF, 1'b1, 64'h1, "R6");
    step(1'b1, 2'd2, 2, 0, 4'h5, 4'h0, 1'b0, 64'h1, "R7");

    // Pseudo-random phase with frequent index aliasing
    for (int n = 0; n < 400; n++) begin
      logic vv;
      vv = ($urandom_range(0, 3) != 0);
      step(vv, 2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3),
           4'($urandom), 4'($urandom), 1'($urandom), {$urandom, $urandom}, "R8");
    end
    idle("R9");
    @(negedge clk);
    compare();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule